// File: doc/BRIEF.md
# Min-Sum Check Node Update Unit

This unit handles one parity check of an iterative LDPC decoder using plain min-sum arithmetic. A caller presents the soft messages of up to `MAX_DEG` bit nodes at once. Each message is an 8-bit two's-complement log-likelihood value. The caller also gives the number of bit nodes actually attached to this check and raises `start` for one cycle. A fixed two cycles later the unit pulses `done`. On that cycle it presents one reply per attached bit node and a flag that tells whether the check's hard decisions already agree.

Every reply is extrinsic. Its magnitude is the smallest absolute value among the other attached inputs. Its sign is the product of the signs of those other inputs. The message from the destination node itself never takes part in its own reply. The unit does not compute each reply separately. Instead it keeps four values: the least magnitude, the second least magnitude, the position of the least one and the XOR of all signs. Each lane then picks its reply from these four values. No scaling or offset is applied to the minimum.

Top module: `cnu_minsum`

## Requirements
- R1: For an attached lane i, the output magnitude equals the minimum absolute value over all other attached inputs. When two inputs share the minimum, both of their replies still carry that minimum.
- R2: For an attached lane i, the output is negative exactly when an odd number of the other attached inputs are negative (sign bit 1). A zero magnitude is output as 0.
- R3: The attached count `degree` is taken at run time. Lanes 0..degree-1 are attached. Values above `MAX_DEG` attach every lane. A degree of 1 gives the single lane the reply +127, because no other input exists.
- R4: The absolute value of -128 saturates to 127. No output lane ever carries -128.
- R5: A negative input means hard bit 1 and a non-negative input means hard bit 0. `parity_ok` is 1 exactly when the XOR of the hard bits of the attached inputs is 0. With degree 0 it is therefore 1.
- R6: Lanes at or above `degree` have no effect on the attached replies or on `parity_ok`, and their outputs are 0.
- R7: `done` is high for exactly one cycle, on the second rising edge after the edge that sampled `start`. `msg_out` and `parity_ok` change only together with `done` and hold their values in between.
- R8: No scaling is applied. A reply magnitude equals the selected minimum exactly, including the values 0 and 1.
- R9: A `start` on consecutive cycles yields a `done` on consecutive cycles, each with its own correct result.
- R10: After reset, `done`, `msg_out` and `parity_ok` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request; samples `degree` and `llr_in` |
| degree | input | $clog2(MAX_DEG+1) | Number of attached lanes |
| llr_in | input | MAX_DEG*8 | Input messages; lane i at bits [8i+7:8i] |
| msg_out | output | MAX_DEG*8 | Extrinsic replies; same lane packing |
| parity_ok | output | 1 | Hard decisions of attached inputs have even parity |
| done | output | 1 | One-cycle result strobe |

## Verification
A wrong least or second-least magnitude shows up on the very next `done`. The one lane that held the true minimum then carries the wrong value, or all the other lanes do. A stale minimum position moves the second minimum onto the wrong lane. A corrupted sign XOR flips every attached reply and also `parity_ok` in the same strobe. A wrong attach mask shows up either as nonzero data in idle lanes or as a perturbed reply when garbage is placed in those lanes. Because the pipeline has a fixed depth of two, any timing fault shows up as a `done` that is missing or early on the third cycle counted from `start`.

// File: rtl/cnu_pkg.sv
package cnu_pkg;
  localparam int LLR_W = 8;
  localparam int MAG_W = LLR_W - 1;

  typedef logic signed [LLR_W-1:0] llr_t;
  typedef logic [MAG_W-1:0]        mag_t;

  localparam mag_t MAG_MAX = '1;

  // magnitude of a message, the most negative code clipped to MAG_MAX
  function automatic mag_t sat_abs(input llr_t v);
    llr_t neg;
    neg = -v;
    if (!v[LLR_W-1])              return v[MAG_W-1:0];
    else if (v[MAG_W-1:0] == '0)  return MAG_MAX;
    else                          return neg[MAG_W-1:0];
  endfunction

  // rebuild a signed message from a magnitude and a sign
  function automatic llr_t with_sign(input mag_t m, input logic s);
    llr_t p;
    p = {1'b0, m};
    return s ? -p : p;
  endfunction
endpackage

// File: rtl/cnu_lane_prep.sv
module cnu_lane_prep
  import cnu_pkg::*;
#(
  parameter int MAX_DEG = 8,
  localparam int DEG_W  = $clog2(MAX_DEG + 1)
) (
  input  logic [MAX_DEG*LLR_W-1:0] llr_flat,
  input  logic [DEG_W-1:0]         deg,
  output logic [MAX_DEG*MAG_W-1:0] mag_flat,
  output logic [MAX_DEG-1:0]       sgn,
  output logic [MAX_DEG-1:0]       act
);
  for (genvar i = 0; i < MAX_DEG; i++) begin : g_lane
    llr_t v;
    assign v      = llr_flat[i*LLR_W +: LLR_W];
    assign act[i] = DEG_W'(i) < deg;
    assign sgn[i] = act[i] & v[LLR_W-1];
    assign mag_flat[i*MAG_W +: MAG_W] = act[i] ? sat_abs(v) : '0;
  end
endmodule

// File: rtl/cnu_min_track.sv
module cnu_min_track
  import cnu_pkg::*;
#(
  parameter int MAX_DEG = 8,
  localparam int IDX_W  = $clog2(MAX_DEG)
) (
  input  logic [MAX_DEG*MAG_W-1:0] mag_flat,
  input  logic [MAX_DEG-1:0]       sgn,
  input  logic [MAX_DEG-1:0]       act,
  output mag_t                     min1,
  output mag_t                     min2,
  output logic [IDX_W-1:0]         idx,
  output logic                     sxor
);
  always_comb begin
    mag_t m;
    min1 = MAG_MAX;
    min2 = MAG_MAX;
    idx  = '0;
    sxor = ^sgn;
    for (int i = 0; i < MAX_DEG; i++) begin
      m = mag_flat[i*MAG_W +: MAG_W];
      if (act[i]) begin
        if (m < min1) begin
          min2 = min1;
          min1 = m;
          idx  = IDX_W'(i);
        end else if (m < min2) begin
          min2 = m;
        end
      end
    end
  end
endmodule

// File: rtl/cnu_reply.sv
module cnu_reply
  import cnu_pkg::*;
#(
  parameter int MAX_DEG = 8,
  localparam int IDX_W  = $clog2(MAX_DEG)
) (
  input  mag_t                     min1,
  input  mag_t                     min2,
  input  logic [IDX_W-1:0]         idx,
  input  logic                     sxor,
  input  logic [MAX_DEG-1:0]       sgn,
  input  logic [MAX_DEG-1:0]       act,
  output logic [MAX_DEG*LLR_W-1:0] msg_flat
);
  for (genvar i = 0; i < MAX_DEG; i++) begin : g_out
    mag_t ext_mag;
    logic ext_sgn;
    assign ext_mag = (idx == IDX_W'(i)) ? min2 : min1;
    assign ext_sgn = sxor ^ sgn[i];
    assign msg_flat[i*LLR_W +: LLR_W] = act[i] ? with_sign(ext_mag, ext_sgn) : '0;
  end
endmodule

// File: rtl/cnu_minsum.sv
module cnu_minsum
  import cnu_pkg::*;
#(
  parameter int MAX_DEG = 8,
  localparam int DEG_W  = $clog2(MAX_DEG + 1),
  localparam int IDX_W  = $clog2(MAX_DEG),
  localparam int VEC_W  = MAX_DEG * LLR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DEG_W-1:0] degree,
  input  logic [VEC_W-1:0] llr_in,
  output logic [VEC_W-1:0] msg_out,
  output logic             parity_ok,
  output logic             done
);
  // stage 1: capture request
  logic             s1_vld;
  logic [DEG_W-1:0] s1_deg;
  logic [VEC_W-1:0] s1_llr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_deg <= '0;
      s1_llr <= '0;
    end else begin
      s1_vld <= start;
      if (start) begin
        s1_deg <= degree;
        s1_llr <= llr_in;
      end
    end
  end

  // named internal events
  logic [MAX_DEG*MAG_W-1:0] mag_flat;
  logic [MAX_DEG-1:0]       sgn, act;
  mag_t                     min1, min2;
  logic [IDX_W-1:0]         min_idx;
  logic                     sxor;
  logic [VEC_W-1:0]         reply;

  cnu_lane_prep #(.MAX_DEG(MAX_DEG)) u_prep (
    .llr_flat(s1_llr), .deg(s1_deg),
    .mag_flat(mag_flat), .sgn(sgn), .act(act)
  );

  cnu_min_track #(.MAX_DEG(MAX_DEG)) u_track (
    .mag_flat(mag_flat), .sgn(sgn), .act(act),
    .min1(min1), .min2(min2), .idx(min_idx), .sxor(sxor)
  );

  cnu_reply #(.MAX_DEG(MAX_DEG)) u_reply (
    .min1(min1), .min2(min2), .idx(min_idx), .sxor(sxor),
    .sgn(sgn), .act(act), .msg_flat(reply)
  );

  // stage 2: result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      msg_out   <= '0;
      parity_ok <= 1'b0;
    end else begin
      done <= s1_vld;
      if (s1_vld) begin
        msg_out   <= reply;
        parity_ok <= ~sxor;
      end
    end
  end

  // ---------------- assertions ----------------
  logic [VEC_W-1:0]   act_wide;
  logic [MAX_DEG-1:0] lane_is_full_neg;
  for (genvar i = 0; i < MAX_DEG; i++) begin : g_chk
    assign act_wide[i*LLR_W +: LLR_W] = {LLR_W{act[i]}};
    assign lane_is_full_neg[i] = (msg_out[i*LLR_W +: LLR_W] == {1'b1, {MAG_W{1'b0}}});
  end

  assert_start_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> s1_vld);
  assert_done_after_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> done);
  assert_no_spurious_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> !done);
  assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> ($stable(msg_out) && $stable(parity_ok)));
  assert_min_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |-> (min1 <= min2));
  assert_min_idx_attached_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && (|act)) |-> act[min_idx]);
  assert_idle_lanes_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> ((msg_out & ~$past(act_wide)) == '0));
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lane_is_full_neg == '0));
endmodule

// File: tb/cnu_minsum_bench.sv
`timescale 1ns/1ps
module cnu_minsum_bench;
  localparam int MD = 8;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] degree = '0;
  logic [63:0]   llr_in = '0;
  logic [63:0]   msg_out;
  logic          parity_ok;
  logic          done;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [63:0] last_msg = '0;

  logic [63:0] q_msg[$];
  logic        q_par[$];
  int          q_cyc[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cnu_minsum #(.MAX_DEG(MD)) u_cnu_minsum (
    .clk(clk), .rst_n(rst_n), .start(start), .degree(degree),
    .llr_in(llr_in), .msg_out(msg_out), .parity_ok(parity_ok), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // independent reference: per destination, scan every other attached input
  task automatic model(input int deg, input logic [63:0] v, output logic [63:0] res, output logic par);
    int eff;
    int hb;
    eff = (deg > MD) ? MD : deg;
    res = '0;
    hb  = 0;
    for (int i = 0; i < eff; i++) begin
      int m;
      int neg;
      int o;
      m = 127;
      neg = 0;
      for (int j = 0; j < eff; j++) begin
        if (j != i) begin
          int a;
          int am;
          a  = int'($signed(v[j*8 +: 8]));
          am = (a < 0) ? ((a == -128) ? 127 : -a) : a;
          if (am < m) m = am;
          if (a < 0) neg = 1 - neg;
        end
      end
      o = (neg == 1) ? -m : m;
      res[i*8 +: 8] = o[7:0];
      if (v[i*8+7]) hb = 1 - hb;
    end
    par = (hb == 0);
  endtask

  task automatic issue(input int deg, input logic [63:0] v, input string tag);
    logic [63:0] e;
    logic p;
    @(negedge clk);
    start  = 1'b1;
    degree = DW'(deg);
    llr_in = v;
    model(deg, v, e, p);
    q_msg.push_back(e);
    q_par.push_back(p);
    q_cyc.push_back(cyc);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    start  = 1'b0;
    llr_in = {8{8'hA5}};
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (done) begin
        if (q_msg.size() == 0) begin
          check(1'b0, "R7 unexpected done", {63'd0, done}, 64'd0);
        end else begin
          logic [63:0] e;
          logic p;
          int ic;
          string t;
          e  = q_msg.pop_front();
          p  = q_par.pop_front();
          ic = q_cyc.pop_front();
          t  = q_tag.pop_front();
          check(cyc == ic + 2, "R7 latency", 64'(cyc), 64'(ic + 2));
          check(msg_out === e, t, msg_out, e);
          check(parity_ok === p, "R5 parity", {63'd0, parity_ok}, {63'd0, p});
          last_msg = msg_out;
        end
      end else if (q_cyc.size() > 0 && cyc >= q_cyc[0] + 2) begin
        check(1'b0, "R7 missing done", {63'd0, done}, 64'd1);
        void'(q_msg.pop_front()); void'(q_par.pop_front());
        void'(q_cyc.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 64'(cyc), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [63:0] pack(input int a0, a1, a2, a3, a4, a5, a6, a7);
    logic [63:0] r;
    r[7:0]   = a0[7:0]; r[15:8]  = a1[7:0]; r[23:16] = a2[7:0]; r[31:24] = a3[7:0];
    r[39:32] = a4[7:0]; r[47:40] = a5[7:0]; r[55:48] = a6[7:0]; r[63:56] = a7[7:0];
    return r;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(done === 1'b0, "R10 done at reset", {63'd0, done}, 64'd0);
    check(msg_out === '0, "R10 msg at reset", msg_out, 64'd0);
    check(parity_ok === 1'b0, "R10 parity at reset", {63'd0, parity_ok}, 64'd0);
    rst_n = 1'b1;
    idle(2);

    issue(4, pack(10, -3, 20, 5, 0, 0, 0, 0), "R1 R2 basic mixed signs"); idle(3);
    issue(3, pack(4, 4, 9, 0, 0, 0, 0, 0), "R1 tied minima"); idle(3);
    issue(5, pack(-128, 7, -2, 60, -90, 0, 0, 0), "R4 saturated abs"); idle(3);
    issue(5, pack(-128, -128, 3, 3, 3, 0, 0, 0), "R4 two saturated minima"); idle(3);
    issue(8, pack(-1, 2, -3, 4, -5, 6, -7, 8), "R3 full degree"); idle(3);
    issue(1, pack(-9, 33, 33, 33, 33, 33, 33, 33), "R3 degree one gives +127"); idle(3);
    issue(0, pack(-1, -1, -1, -1, -1, -1, -1, -1), "R5 R6 degree zero"); idle(3);
    issue(3, pack(50, -40, 30, -1, -128, 0, 2, -2), "R6 garbage upper lanes"); idle(3);
    issue(12, pack(20, 30, -40, 50, 60, -70, 80, 90), "R3 degree above max"); idle(3);
    issue(3, pack(1, 100, -50, 0, 0, 0, 0, 0), "R8 exact unit minimum"); idle(3);
    issue(4, pack(0, -6, 6, -6, 0, 0, 0, 0), "R2 R8 zero magnitude"); idle(3);

    issue(4, pack(-8, -9, -10, -11, 0, 0, 0, 0), "R9 back-to-back a");
    issue(2, pack(15, -25, 0, 0, 0, 0, 0, 0), "R9 back-to-back b");
    issue(6, pack(3, 1, 4, 1, -5, 9, 0, 0), "R9 back-to-back c");
    idle(6);
    check(msg_out === last_msg, "R7 hold while idle", msg_out, last_msg);

    for (int k = 0; k < 80; k++) begin
      logic [63:0] rv;
      rv = {$urandom(), $urandom()};
      issue($urandom_range(0, 9), rv, "R1 R2 R6 random");
      if (k % 3 == 0) idle($urandom_range(0, 3));
    end
    idle(6);
    check(q_msg.size() == 0, "R7 all results delivered", 64'(q_msg.size()), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule